// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to a usable state. Out of reset it keeps the clock enable low and drives NOP for a programmable settling time. It then raises the clock enable and works through the DDR2 power-up command order, one command per step, with chip select held active throughout. That order is: precharge-all; writes to the second and third extended mode registers; a DLL-enable write to the first extended register; a mode register write that resets the DLL, followed by the lock wait; a second precharge-all; two auto refreshes; a mode register write that releases DLL reset; and finally an enter and an exit of the driver-calibration default setting.

Every gap between commands is a parameter in controller clock cycles: settle time, clock-enable-to-precharge time, precharge period, refresh cycle time, mode-register cycle time and DLL lock time. The burst length, CAS latency and write recovery fields of the mode register also come from parameters.

After the last mode write, the block raises a strobe that allows the read datapath to run its dummy-read calibration. It then waits for a calibration-done input. When that input is seen, the strobe drops and a sticky init-done output rises, which hands the memory to the main command scheduler.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While reset is high and after it is released, cke is 0, {ras_n,cas_n,we_n} is 3'b111 (NOP), cal_start is 0 and init_done is 0. cke stays 0 for exactly PWRUP_CYC clock cycles after reset is released.
- R2: The first command is precharge-all ({ras_n,cas_n,we_n}=3'b010, addr bit 10 = 1, other address and bank bits 0). It appears exactly CKE_PRE_CYC cycles after cke rises. cke never falls again, and no command is ever driven while cke is 0.
- R3: The second and third commands are mode writes ({ras_n,cas_n,we_n}=3'b000) with ba=2 and then ba=3, each with addr all zero. Each follows the command before it by TRP_CYC and TMRD_CYC cycles respectively.
- R4: The fourth command is a mode write with ba=1 and addr all zero, which enables the DLL. The fifth is a mode write with ba=0 and addr bit 8 set (DLL reset). Each follows the previous command by TMRD_CYC cycles.
- R5: Mode register words (ba=0) carry addr[2:0]=3'b010 for burst 4 or 3'b011 for burst 8, addr[3]=0, addr[6:4]=CAS latency, addr[11:9]=write recovery minus one, and 0 in every other bit except bit 8.
- R6: The command after the DLL-reset write follows it by exactly DLL_LOCK_CYC cycles.
- R7: Commands six to eight are precharge-all, then auto refresh ({ras_n,cas_n,we_n}=3'b001, ba and addr zero), then auto refresh. The first refresh follows the precharge by TRP_CYC cycles, and the next command follows each refresh by TRFC_CYC cycles.
- R8: Commands nine to eleven are a ba=0 mode write with bit 8 clear, then a ba=1 write with addr[9:7]=3'b111 and all other bits 0, then a ba=1 write with addr all zero. They are spaced TMRD_CYC cycles apart.
- R9: Exactly eleven commands are issued, each for one cycle, and every other cycle carries NOP. cs_n is always 0.
- R10: cal_start rises TMRD_CYC cycles after the eleventh command and stays high until cal_done is sampled high while cal_start is high. In the next cycle cal_start is 0 and init_done is 1. From then on init_done stays 1, and only NOP is driven.
- R11: cal_done pulses before cal_start rises, and any cal_done activity after init_done, have no effect on the command order, the gaps or the outputs.
- R12: If cal_done is already high when cal_start rises, cal_start stays high for exactly one cycle and init_done rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Read datapath reports that calibration has finished |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low, always asserted |
| ras_n | output | 1 | Row strobe command bit |
| cas_n | output | 1 | Column strobe command bit |
| we_n | output | 1 | Write enable command bit |
| ba | output | BA_W | Bank / mode register select |
| addr | output | ROW_W | Memory address bus |
| cal_start | output | 1 | Dummy-read calibration may run |
| init_done | output | 1 | Initialization complete, sticky |

## Verification
The calibration strobe and its completion can fall in the same cycle. This happens when cal_done is already high at the moment cal_start first becomes visible, so the strobe must then last one cycle and init_done must follow on the next sample. The bench provokes this by holding cal_done high from the eleventh command onward. In other runs it returns cal_done after a random number of cycles, or toggles it at random throughout the command phase, and then checks the full command trace and every gap against a schedule it builds from the parameters.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    // Command bits in the order {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } cmd_e;

    // Steps in issue order; the sequencer advances by incrementing
    typedef enum logic [3:0] {
        ST_PWR,
        ST_CKE,
        ST_PREA1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_DLL,
        ST_MR_DLLRST,
        ST_PREA2,
        ST_REF1,
        ST_REF2,
        ST_MR_RUN,
        ST_OCD_DEF,
        ST_OCD_EXIT,
        ST_CAL,
        ST_DONE
    } step_e;

    typedef struct packed {
        cmd_e        cmd;
        logic [1:0]  ba;
        logic [15:0] addr;
    } pin_word_t;

    localparam logic [15:0] PREA_ADDR = 16'h0400;   // bit 10 selects all banks
    localparam logic [15:0] OCD_DEF   = 16'h0380;   // bits 9:7 set

    function automatic logic [15:0] mr_word(input int bl, input int cl,
                                            input int wr, input logic dll_rst);
        logic [15:0] w;
        w       = '0;
        w[2:0]  = (bl == 8) ? 3'b011 : 3'b010;
        w[6:4]  = 3'(cl);
        w[8]    = dll_rst;
        w[11:9] = 3'(wr - 1);
        return w;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TIMER_DEC: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));   // R6

endmodule

// File: rtl/pwrup_cmd_dec.sv
module pwrup_cmd_dec
    import pwrup_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int WR_REC    = 3
) (
    input  step_e     step,
    output pin_word_t word
);

    always_comb begin
        word = '{cmd: CMD_NOP, ba: 2'd0, addr: 16'd0};
        case (step)
            ST_PREA1, ST_PREA2: word = '{cmd: CMD_PRE, ba: 2'd0, addr: PREA_ADDR};
            ST_EMR2:            word = '{cmd: CMD_MRS, ba: 2'd2, addr: 16'd0};
            ST_EMR3:            word = '{cmd: CMD_MRS, ba: 2'd3, addr: 16'd0};
            ST_EMR1_DLL:        word = '{cmd: CMD_MRS, ba: 2'd1, addr: 16'd0};
            ST_MR_DLLRST:       word = '{cmd: CMD_MRS, ba: 2'd0,
                                         addr: mr_word(BURST_LEN, CAS_LAT, WR_REC, 1'b1)};
            ST_REF1, ST_REF2:   word = '{cmd: CMD_REF, ba: 2'd0, addr: 16'd0};
            ST_MR_RUN:          word = '{cmd: CMD_MRS, ba: 2'd0,
                                         addr: mr_word(BURST_LEN, CAS_LAT, WR_REC, 1'b0)};
            ST_OCD_DEF:         word = '{cmd: CMD_MRS, ba: 2'd1, addr: OCD_DEF};
            ST_OCD_EXIT:        word = '{cmd: CMD_MRS, ba: 2'd1, addr: 16'd0};
            default:            word = '{cmd: CMD_NOP, ba: 2'd0, addr: 16'd0};
        endcase
    end

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int PWRUP_CYC    = 26700,
    parameter int CKE_PRE_CYC  = 54,
    parameter int TRP_CYC      = 3,
    parameter int TRFC_CYC     = 18,
    parameter int TMRD_CYC     = 2,
    parameter int DLL_LOCK_CYC = 200,
    parameter int BURST_LEN    = 4,
    parameter int CAS_LAT      = 3,
    parameter int WR_REC       = 3,
    parameter int BA_W         = 3,
    parameter int ROW_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_done,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output logic             cal_start,
    output logic             init_done
);

    localparam int MAX_WAIT = max_of(max_of(max_of(PWRUP_CYC, CKE_PRE_CYC),
                                            max_of(TRP_CYC, TRFC_CYC)),
                                     max_of(TMRD_CYC, DLL_LOCK_CYC));
    localparam int CNT_W = $clog2(MAX_WAIT + 1);

    step_e            step_q, step_d;
    logic             adv, tmr_zero, issue_q;
    logic [CNT_W-1:0] wait_len;
    pin_word_t        word;

    // Advance: timed steps on expiry, calibration on a seen handshake
    always_comb begin
        if (step_q == ST_CAL)
            adv = cal_start && cal_done;
        else
            adv = (step_q != ST_DONE) && tmr_zero;
        step_d = adv ? step_e'(step_q + 4'd1) : step_q;
    end

    // Length of the step being entered, minus one
    always_comb begin
        case (step_d)
            ST_CKE:                          wait_len = CNT_W'(CKE_PRE_CYC - 1);
            ST_PREA1, ST_PREA2:              wait_len = CNT_W'(TRP_CYC - 1);
            ST_REF1, ST_REF2:                wait_len = CNT_W'(TRFC_CYC - 1);
            ST_MR_DLLRST:                    wait_len = CNT_W'(DLL_LOCK_CYC - 1);
            ST_EMR2, ST_EMR3, ST_EMR1_DLL,
            ST_MR_RUN, ST_OCD_DEF,
            ST_OCD_EXIT:                     wait_len = CNT_W'(TMRD_CYC - 1);
            default:                         wait_len = '0;
        endcase
    end

    pwrup_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (adv),
        .load_val (wait_len),
        .zero     (tmr_zero)
    );

    pwrup_cmd_dec #(
        .BURST_LEN (BURST_LEN),
        .CAS_LAT   (CAS_LAT),
        .WR_REC    (WR_REC)
    ) u_dec (
        .step (step_q),
        .word (word)
    );

    assign cs_n = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= ST_PWR;
            issue_q   <= 1'b0;
            cke       <= 1'b0;
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
            we_n      <= 1'b1;
            ba        <= '0;
            addr      <= '0;
            cal_start <= 1'b0;
            init_done <= 1'b0;
        end else begin
            step_q  <= step_d;
            issue_q <= adv;
            cke     <= (step_q != ST_PWR);
            if (issue_q) begin
                {ras_n, cas_n, we_n} <= word.cmd;
                ba                   <= BA_W'(word.ba);
                addr                 <= ROW_W'(word.addr);
            end else begin
                {ras_n, cas_n, we_n} <= CMD_NOP;
                ba                   <= '0;
                addr                 <= '0;
            end
            cal_start <= (step_q == ST_CAL) && !adv;
            init_done <= init_done || ((step_q == ST_CAL) && adv);
        end
    end

    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);                                                    // R2
    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
        ({ras_n, cas_n, we_n} != 3'b111) |-> cke);                       // R2
    AST_START_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cal_start && init_done));                                      // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);                                        // R10
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> ({ras_n, cas_n, we_n} == 3'b111));                 // R10
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(cal_start));                          // R11

endmodule

// File: tb/ddr2_pwrup_seq_bench.sv
`timescale 1ns/1ps
module ddr2_pwrup_seq_bench;

    localparam int PW  = 40;
    localparam int CP  = 6;
    localparam int RP  = 3;
    localparam int RFC = 9;
    localparam int MRD = 2;
    localparam int DLL = 200;
    localparam int BL  = 8;
    localparam int CL  = 5;
    localparam int WR  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cal_done = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, cal_start, init_done;
    logic [2:0]  ba;
    logic [15:0] addr;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ddr2_pwrup_seq #(
        .PWRUP_CYC(PW), .CKE_PRE_CYC(CP), .TRP_CYC(RP), .TRFC_CYC(RFC),
        .TMRD_CYC(MRD), .DLL_LOCK_CYC(DLL), .BURST_LEN(BL), .CAS_LAT(CL),
        .WR_REC(WR)
    ) u_ddr2_pwrup_seq (
        .clk(clk), .rst(rst), .cal_done(cal_done), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cal_start(cal_start), .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mrv(input bit dll_rst);
        logic [15:0] v;
        v = 16'((BL == 8) ? 3 : 2);
        v = v | 16'(CL << 4) | 16'(int'(dll_rst) << 8) | 16'((WR - 1) << 9);
        return v;
    endfunction

    function automatic logic [2:0] e_cmd(input int i);
        if (i == 0 || i == 5) return 3'b010;
        if (i == 6 || i == 7) return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic [2:0] e_ba(input int i);
        case (i)
            1: return 3'd2;
            2: return 3'd3;
            3, 9, 10: return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [15:0] e_addr(input int i);
        case (i)
            0, 5: return 16'h0400;
            4: return mrv(1'b1);
            8: return mrv(1'b0);
            9: return 16'h0380;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int e_gap(input int i);
        case (i)
            0: return CP;
            1, 6: return RP;
            5: return DLL;
            7, 8: return RFC;
            default: return MRD;
        endcase
    endfunction

    function automatic string tag(input int i);
        if (i == 0) return "R2";
        if (i <= 2) return "R3";
        if (i == 4) return "R5";
        if (i == 3) return "R4";
        if (i <= 7) return "R7";
        return "R8";
    endfunction

    task automatic step_smp();
        @(posedge clk);
        @(negedge clk);
    endtask

    // mode 0: quiet cal_done, 1: noise on cal_done, 2: cal_done held early
    task automatic run_seq(input int mode, input int dly);
        int          cyc, ncmd, cke_cyc, start_cyc;
        bit          cke_fell, early_done, cs_bad, hold_ok;
        int          ccyc[16];
        logic [2:0]  ccmd[16];
        logic [2:0]  cba[16];
        logic [15:0] caddr[16];
        rst = 1'b1;
        cal_done = 1'b0;
        repeat (3) step_smp();
        chk(cke == 1'b0 && {ras_n, cas_n, we_n} == 3'b111 && cal_start == 1'b0
            && init_done == 1'b0 && cs_n == 1'b0, "R1", "reset outputs",
            {cke, ras_n, cas_n, we_n, cal_start, init_done}, 6'b011100);
        rst = 1'b0;
        cyc = 0; ncmd = 0; cke_cyc = -1; start_cyc = -1;
        cke_fell = 0; early_done = 0; cs_bad = 0;
        while (start_cyc < 0 && cyc < 2000) begin
            step_smp();
            cyc++;
            if (cke && cke_cyc < 0) cke_cyc = cyc;
            if (!cke && cke_cyc >= 0) cke_fell = 1;
            if (cs_n) cs_bad = 1;
            if ({ras_n, cas_n, we_n} != 3'b111) begin
                if (ncmd < 16) begin
                    ccyc[ncmd] = cyc; ccmd[ncmd] = {ras_n, cas_n, we_n};
                    cba[ncmd] = ba; caddr[ncmd] = addr;
                end
                ncmd++;
            end
            if (init_done) early_done = 1;
            if (cal_start) start_cyc = cyc;
            if (ncmd < 11) cal_done = (mode == 1) ? 1'($urandom % 2) : 1'b0;
            else cal_done = (mode == 2);
        end
        chk(cke_cyc == PW + 1, "R1", "cke low cycles", cke_cyc - 1, PW);
        chk(!cke_fell, "R2", "cke fell after rising", cke_fell, 0);
        chk(ncmd == 11 && !cs_bad, "R9", "command count", ncmd, 11);
        chk(!early_done, "R11", "init_done before cal_start", early_done, 0);
        for (int i = 0; i < 11 && i < ncmd; i++) begin
            chk(ccmd[i] == e_cmd(i), tag(i), $sformatf("cmd %0d code", i), ccmd[i], e_cmd(i));
            chk(cba[i] == e_ba(i), tag(i), $sformatf("cmd %0d bank", i), cba[i], e_ba(i));
            chk(caddr[i] == e_addr(i), tag(i), $sformatf("cmd %0d addr", i), caddr[i], e_addr(i));
            if (i == 0)
                chk(ccyc[0] - cke_cyc == CP, "R2", "cke to precharge", ccyc[0] - cke_cyc, CP);
            else if (i == 5)
                chk(ccyc[5] - ccyc[4] == DLL, "R6", "DLL lock gap", ccyc[5] - ccyc[4], DLL);
            else
                chk(ccyc[i] - ccyc[i-1] == e_gap(i), tag(i), $sformatf("gap before cmd %0d", i),
                    ccyc[i] - ccyc[i-1], e_gap(i));
        end
        if (ncmd >= 11)
            chk(start_cyc - ccyc[10] == MRD, "R10", "cal_start delay", start_cyc - ccyc[10], MRD);
        if (mode == 2) begin
            step_smp();
            chk(cal_start == 1'b0 && init_done == 1'b1, "R12", "one-cycle strobe",
                {cal_start, init_done}, 2'b01);
        end else begin
            hold_ok = 1;
            for (int k = 0; k < dly; k++) begin
                step_smp();
                if (!(cal_start && !init_done)) hold_ok = 0;
            end
            chk(hold_ok, "R10", "cal_start held while waiting", hold_ok, 1);
            cal_done = 1'b1;
            step_smp();
            chk(cal_start == 1'b0 && init_done == 1'b1, "R10", "handshake finish",
                {cal_start, init_done}, 2'b01);
        end
        hold_ok = 1;
        for (int k = 0; k < 6; k++) begin
            cal_done = 1'($urandom % 2);
            step_smp();
            if (!(init_done && !cal_start && {ras_n, cas_n, we_n} == 3'b111 && cke)) hold_ok = 0;
        end
        chk(hold_ok, "R11", "quiet after done with cal_done noise", hold_ok, 1);
        cal_done = 1'b0;
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        run_seq(0, 3);
        run_seq(1, 0);
        run_seq(2, 0);
        for (int r = 0; r < 3; r++)
            run_seq(int'($urandom % 3), int'($urandom % 8));
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule